// File: doc/BRIEF.md
# Framed Packet FIFO Bridge

This block sits between a 32-bit word-addressed processor bus and a framed streaming link. Outgoing words are written one at a time to a data register. Each word is queued in a transmit FIFO together with four framing bits: start of frame, end of frame and a two-bit byte remainder. Software stages these bits in a control register before the push. The transmit FIFO presents its head word on a valid/ready link output. Incoming link words are queued in a receive FIFO. Software checks the framing bits of the head word through the status register, and pops the word by reading the data register.

A frame's first word is marked start-of-frame and its last word end-of-frame, and a one-word frame carries both marks. The remainder on the final word is (byte length − 1) mod 4, so a reader recovers the byte length as 4·words − 3 + remainder. A transmit almost-full flag lets software push a whole burst of words after one check. A group of control bits flushes both FIFOs for as long as any of them is set.

Top module: `framed_fifo_bridge`

## Requirements
- R1: The bus selects registers by word offset: 0 is control, 1 is status and 2 is data. Reading offset 0 returns the last value written to the control register.
- R2: A write to offset 2 queues the write data for the link. The word is tagged with control bits 28 (start), 29 (end) and 31:30 (remainder) as they stand at the time of the write.
- R3: A data write while the transmit FIFO holds DEPTH words is discarded and sets status bit 0. The bit stays set until a flush or a bus reset clears it.
- R4: Status bit 24 is 1 exactly when fewer than AFULL_GAP transmit entries are free.
- R5: Status bit 27 is 1 when the receive FIFO is empty. When it is not empty, status bits 28, 29 and 31:30 give the start, end and remainder tags of the head receive word. When it is empty, those bits are 0.
- R6: A read of offset 2 returns the head receive word and removes it, and the status then describes the next word. A read of offset 2 with an empty receive FIFO returns 0 and removes nothing.
- R7: A link word is accepted in any cycle where rx_valid and rx_ready are both high. rx_ready is low whenever the receive FIFO holds DEPTH words.
- R8: While any control bit in the mask 0x0CE00000 is 1, the block does the following: both FIFOs are emptied, status bit 0 is cleared, tx_valid and rx_ready are low, and data writes are discarded. Normal operation resumes once those bits are written back to 0.
- R9: tx_valid is high whenever a transmit word is queued. The head word and its tags stay unchanged until a cycle with tx_ready high, and words leave in the order they were written.
- R10: After rst_n is low at a clock edge, the control register reads 0, status reads 0x08000000, tx_valid is 0 and rx_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops when offset is 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tx_valid | output | 1 | Transmit word available |
| tx_ready | input | 1 | Link takes the transmit word |
| tx_data | output | 32 | Transmit data word |
| tx_sof | output | 1 | Transmit start-of-frame tag |
| tx_eof | output | 1 | Transmit end-of-frame tag |
| tx_rem | output | 2 | Transmit remainder tag |
| rx_valid | input | 1 | Link offers a receive word |
| rx_ready | output | 1 | Receive FIFO can accept |
| rx_data | input | 32 | Receive data word |
| rx_sof | input | 1 | Receive start-of-frame tag |
| rx_eof | input | 1 | Receive end-of-frame tag |
| rx_rem | input | 2 | Receive remainder tag |

## Verification
The bench builds the block with a FIFO depth of 16 and an almost-full gap of 4. With these values a handful of writes reaches the almost-full boundary at 13 entries, a completely full transmit FIFO, the discarded seventeenth write and receive backpressure. The default depth of 512 would need hundreds of cycles per boundary and would exercise no different logic. A queue-based model tracks both FIFOs, the control word and the overflow flag, and the bench compares every output against it on every clock. This covers flushes that arrive while words are queued and pushes and pops in the same cycle.

// File: rtl/bridge_pkg.sv
// Package: shared register offsets, bit positions and the queued word type
// for the framed FIFO bridge. Assumes a 32-bit data word.
package bridge_pkg;

    localparam int WORD_W = 32;

    // register word offsets
    localparam int OFF_CTRL = 0;
    localparam int OFF_STAT = 1;
    localparam int OFF_DATA = 2;

    // framing field position, shared by control and status
    localparam int TAG_SOF    = 28;
    localparam int TAG_EOF    = 29;
    localparam int TAG_REM_LO = 30;

    // status flag positions
    localparam int STAT_RX_EMPTY = 27;
    localparam int STAT_TX_AFULL = 24;
    localparam int STAT_TX_OVF   = 0;

    // control bits that hold the datapath flushed
    localparam logic [WORD_W-1:0] FLUSH_MASK = 32'h0CE0_0000;

    typedef struct packed {
        logic [1:0]        rem;
        logic              eof;
        logic              sof;
        logic [WORD_W-1:0] data;
    } link_word_t;

endpackage

// File: rtl/frame_fifo.sv
// Module: frame_fifo
// Synchronous FIFO of link words with first-word fall-through head output.
// Assumes DEPTH >= 2 and 1 <= AFULL_GAP <= DEPTH. A synchronous clear
// empties it and masks every flag for the cycle it is held. A push into a
// full FIFO is ignored; fullness is judged before any same-cycle pop.
module frame_fifo
    import bridge_pkg::*;
#(
    parameter int DEPTH     = 512,
    parameter int AFULL_GAP = 100,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  link_word_t       push_word,
    input  logic             pop,
    output link_word_t       head,
    output logic             not_empty,
    output logic             full,
    output logic             afull,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_AFULL = CNT_W'(DEPTH - AFULL_GAP);
    localparam logic [PTR_W-1:0] PTR_LAST  = PTR_W'(DEPTH - 1);

    link_word_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    // qualify requests against occupancy and clear
    always_comb begin
        do_push = push && !clr && (count != CNT_FULL);
        do_pop  = pop && !clr && (count != '0);
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end

    // storage write, no reset needed on the array
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_word;
        end
    end

    // head word and flags, masked while clearing
    always_comb begin
        head      = mem[rd_ptr];
        not_empty = !clr && (count != '0);
        full      = !clr && (count == CNT_FULL);
        afull     = !clr && (count > CNT_AFULL);
    end

endmodule

// File: rtl/bridge_csr.sv
// Module: bridge_csr
// Register file of the bridge: the control word, the sticky overflow flag,
// the read multiplexer and the decode of data pushes and pops.
// Assumes the FIFO flags it receives are already masked during a flush.
module bridge_csr
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              tx_full,
    input  logic              tx_afull,
    input  logic              rx_not_empty,
    input  link_word_t        rx_head,
    output logic              tx_push,
    output link_word_t        tx_word,
    output logic              rx_pop,
    output logic              flush
);

    logic [WORD_W-1:0] ctrl_q;
    logic              ovf_q;
    logic              sel_ctrl;
    logic              sel_stat;
    logic              sel_data;
    logic [WORD_W-1:0] status;

    // address decode
    always_comb begin
        sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
        sel_stat = (bus_addr == ADDR_W'(OFF_STAT));
        sel_data = (bus_addr == ADDR_W'(OFF_DATA));
    end

    // control word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && sel_ctrl) begin
            ctrl_q <= bus_wdata;
        end
    end

    // sticky overflow on a push into a full transmit FIFO
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ovf_q <= 1'b0;
        end else if (bus_wr && sel_data && tx_full) begin
            ovf_q <= 1'b1;
        end
    end

    // flush request and FIFO side decode
    always_comb begin
        flush        = |(ctrl_q & FLUSH_MASK);
        tx_push      = bus_wr && sel_data && !flush;
        tx_word.data = bus_wdata;
        tx_word.sof  = ctrl_q[TAG_SOF];
        tx_word.eof  = ctrl_q[TAG_EOF];
        tx_word.rem  = ctrl_q[TAG_REM_LO +: 2];
        rx_pop       = bus_rd && sel_data && rx_not_empty;
    end

    // status word assembly
    always_comb begin
        status                = '0;
        status[STAT_TX_OVF]   = ovf_q;
        status[STAT_TX_AFULL] = tx_afull;
        status[STAT_RX_EMPTY] = !rx_not_empty;
        if (rx_not_empty) begin
            status[TAG_SOF]         = rx_head.sof;
            status[TAG_EOF]         = rx_head.eof;
            status[TAG_REM_LO +: 2] = rx_head.rem;
        end
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata = ctrl_q;
        end else if (sel_stat) begin
            bus_rdata = status;
        end else if (sel_data && rx_not_empty) begin
            bus_rdata = rx_head.data;
        end
    end

endmodule

// File: rtl/framed_fifo_bridge.sv
// Module: framed_fifo_bridge
// Bus-to-link bridge with one transmit and one receive FIFO of tagged words.
// Assumes single-cycle bus strobes and a combinational read path; the link
// side uses valid/ready with transfer on both high at a clock edge.
module framed_fifo_bridge
    import bridge_pkg::*;
#(
    parameter int FIFO_DEPTH = 512,
    parameter int AFULL_GAP  = 100,
    parameter int ADDR_W     = 2,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [31:0]       tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    output logic [1:0]        tx_rem,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [31:0]       rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [1:0]        rx_rem
);

    logic             flush;
    logic             tx_push;
    link_word_t       tx_word;
    link_word_t       tx_head;
    logic             tx_not_empty;
    logic             tx_full;
    logic             tx_afull;
    logic [CNT_W-1:0] tx_cnt;
    logic             rx_pop;
    link_word_t       rx_word;
    link_word_t       rx_head;
    logic             rx_not_empty;
    logic             rx_full;
    logic             rx_afull_unused;
    logic [CNT_W-1:0] rx_cnt;

    bridge_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .tx_full      (tx_full),
        .tx_afull     (tx_afull),
        .rx_not_empty (rx_not_empty),
        .rx_head      (rx_head),
        .tx_push      (tx_push),
        .tx_word      (tx_word),
        .rx_pop       (rx_pop),
        .flush        (flush)
    );

    frame_fifo #(.DEPTH(FIFO_DEPTH), .AFULL_GAP(AFULL_GAP)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush),
        .push      (tx_push),
        .push_word (tx_word),
        .pop       (tx_valid && tx_ready),
        .head      (tx_head),
        .not_empty (tx_not_empty),
        .full      (tx_full),
        .afull     (tx_afull),
        .count     (tx_cnt)
    );

    frame_fifo #(.DEPTH(FIFO_DEPTH), .AFULL_GAP(AFULL_GAP)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush),
        .push      (rx_valid && rx_ready),
        .push_word (rx_word),
        .pop       (rx_pop),
        .head      (rx_head),
        .not_empty (rx_not_empty),
        .full      (rx_full),
        .afull     (rx_afull_unused),
        .count     (rx_cnt)
    );

    // link side wiring of both directions
    always_comb begin
        tx_valid     = tx_not_empty;
        tx_data      = tx_head.data;
        tx_sof       = tx_head.sof;
        tx_eof       = tx_head.eof;
        tx_rem       = tx_head.rem;
        rx_ready     = !flush && !rx_full;
        rx_word.data = rx_data;
        rx_word.sof  = rx_sof;
        rx_word.eof  = rx_eof;
        rx_word.rem  = rx_rem;
    end

endmodule

// File: rtl/bridge_checker.sv
// Module: bridge_checker
// Temporal properties of framed_fifo_bridge, attached by bind below.
// Assumes the observed occupancy counts come from the two FIFO instances.
module bridge_checker
    import bridge_pkg::*;
#(
    parameter int DEPTH     = 512,
    parameter int AFULL_GAP = 100,
    parameter int ADDR_W    = 2,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [31:0]       tx_data,
    input logic              tx_sof,
    input logic              tx_eof,
    input logic [1:0]        tx_rem,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              flush,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic              rx_afull_unused
);

    localparam logic [CNT_W-1:0] C_FULL  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] C_AFULL = CNT_W'(DEPTH - AFULL_GAP);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);

    logic unused_ok;
    assign unused_ok = rx_afull_unused;

    p_ctrl_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bus_wr && bus_addr == A_CTRL) && bus_addr == A_CTRL
        |-> bus_rdata == $past(bus_wdata));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flush && tx_cnt == C_FULL && bus_wr && bus_addr == A_DATA
        |=> (bus_addr != A_STAT) || bus_rdata[STAT_TX_OVF]);

    p_afull_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !flush && bus_addr == A_STAT && tx_cnt > C_AFULL |-> bus_rdata[STAT_TX_AFULL]);

    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == A_DATA && rx_cnt == '0 |-> bus_rdata == '0);

    p_pop_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flush && bus_rd && bus_addr == A_DATA && rx_cnt != '0 && !(rx_valid && rx_ready)
        |=> rx_cnt == $past(rx_cnt) - 1'b1);

    p_backpressure_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt == C_FULL |-> !rx_ready);

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush && $past(flush) && $past(rst_n)
        |-> tx_cnt == '0 && rx_cnt == '0 && !tx_valid && !rx_ready);

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> flush ||
        (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof) && $stable(tx_rem)));

endmodule

bind framed_fifo_bridge bridge_checker #(
    .DEPTH     (FIFO_DEPTH),
    .AFULL_GAP (AFULL_GAP),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_wr          (bus_wr),
    .bus_rd          (bus_rd),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .tx_valid        (tx_valid),
    .tx_ready        (tx_ready),
    .tx_data         (tx_data),
    .tx_sof          (tx_sof),
    .tx_eof          (tx_eof),
    .tx_rem          (tx_rem),
    .rx_valid        (rx_valid),
    .rx_ready        (rx_ready),
    .flush           (flush),
    .tx_cnt          (tx_cnt),
    .rx_cnt          (rx_cnt),
    .rx_afull_unused (rx_afull_unused)
);

// File: tb/tb_framed_fifo_bridge.sv
module tb_framed_fifo_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int GAP        = 4;
    localparam logic [31:0] FMASK = 32'h0CE0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  b_addr = '0;
    logic        b_wr = 1'b0;
    logic        b_rd = 1'b0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic        tx_valid, tx_sof, tx_eof;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic [1:0]  tx_rem;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [31:0] rx_data = '0;
    logic        rx_sof = 1'b0, rx_eof = 1'b0;
    logic [1:0]  rx_rem = '0;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    framed_fifo_bridge #(.FIFO_DEPTH(DEPTH), .AFULL_GAP(GAP), .ADDR_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_rem(tx_rem),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_rem(rx_rem)
    );

    // ---------------- reference model: queues of {rem,eof,sof,data}
    logic [35:0] txq[$];
    logic [35:0] rxq[$];
    logic [31:0] m_ctrl = '0;
    bit          m_ovf = 0;

    function automatic bit m_flush();
        return (m_ctrl & FMASK) != 0;
    endfunction

    function automatic logic [31:0] m_rdata(input logic [1:0] a);
        logic [31:0] s;
        bit empty;
        empty = m_flush() || rxq.size() == 0;
        s = '0;
        if (a == 2'd0) return m_ctrl;
        if (a == 2'd1) begin
            s[0]  = m_ovf;
            s[24] = !m_flush() && (DEPTH - txq.size()) < GAP;
            s[27] = empty;
            if (!empty) s[31:28] = rxq[0][35:32];
            return s;
        end
        if (a == 2'd2 && !empty) return rxq[0][31:0];
        return '0;
    endfunction

    // model state update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete(); m_ctrl = '0; m_ovf = 0;
        end else begin
            if (m_flush()) begin
                txq.delete(); rxq.delete(); m_ovf = 0;
            end else begin
                bit txfull, rxfull;
                txfull = txq.size() == DEPTH;
                rxfull = rxq.size() == DEPTH;
                if (tx_ready && txq.size() > 0) void'(txq.pop_front());
                if (b_wr && b_addr == 2'd2) begin
                    if (txfull) m_ovf = 1;
                    else txq.push_back({m_ctrl[31:28], b_wdata});
                end
                if (b_rd && b_addr == 2'd2 && rxq.size() > 0) void'(rxq.pop_front());
                if (rx_valid && !rxfull) rxq.push_back({rx_rem, rx_eof, rx_sof, rx_data});
            end
            if (b_wr && b_addr == 2'd0) m_ctrl = b_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] er;
            bit ev, erdy;
            er   = m_rdata(b_addr);
            ev   = !m_flush() && txq.size() > 0;
            erdy = !m_flush() && rxq.size() < DEPTH;
            check(b_rdata === er, "R1/R5/R6 model rdata", b_rdata, er);
            check(tx_valid === ev, "R9 model tx_valid", 32'(tx_valid), 32'(ev));
            check(rx_ready === erdy, "R7/R8 model rx_ready", 32'(rx_ready), 32'(erdy));
            if (ev) begin
                check({tx_rem, tx_eof, tx_sof, tx_data} === txq[0], "R2 model tx word",
                      tx_data, txq[0][31:0]);
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        b_addr = a; b_wdata = d; b_wr = 1'b1;
        @(posedge clk); #1;
        b_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        b_addr = a; b_rd = 1'b1;
        #1 d = b_rdata;
        @(posedge clk); #1;
        b_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state
        bus_read(2'd1, v);
        check(v == 32'h0800_0000, "R10 status after reset", v, 32'h0800_0000);
        bus_read(2'd0, v);
        check(v == 32'h0, "R10 ctrl after reset", v, 32'h0);
        check(tx_valid == 1'b0, "R10 tx_valid", 32'(tx_valid), 0);
        check(rx_ready == 1'b1, "R10 rx_ready", 32'(rx_ready), 1);

        // R1: control readback
        bus_write(2'd0, 32'h5000_1234);
        bus_read(2'd0, v);
        check(v == 32'h5000_1234, "R1 ctrl readback", v, 32'h5000_1234);

        // R2/R9: three-word frame of 10 bytes, link stalled first
        bus_write(2'd0, 32'h1000_0000);
        bus_write(2'd2, 32'hAAAA_0001);
        bus_write(2'd0, 32'h0);
        bus_write(2'd2, 32'hAAAA_0002);
        bus_write(2'd0, 32'h6000_0000);   // eof, rem = 1
        bus_write(2'd2, 32'hAAAA_0003);
        repeat (3) @(negedge clk);
        #2 check(tx_valid && tx_sof && tx_data == 32'hAAAA_0001, "R9 head held while stalled",
                 tx_data, 32'hAAAA_0001);
        tx_ready = 1'b1;
        @(negedge clk); #2
        check(tx_valid && !tx_sof && !tx_eof && tx_data == 32'hAAAA_0002, "R9 second word",
              tx_data, 32'hAAAA_0002);
        @(negedge clk); #2
        check(tx_valid && tx_eof && tx_rem == 2'd1 && tx_data == 32'hAAAA_0003,
              "R2 last word tags", {tx_rem, tx_eof, tx_sof, tx_data[27:0]}, 32'h6AAA_0003);
        check(4 * 3 - 3 + int'(tx_rem) == 10, "R2 frame length from remainder",
              32'(4 * 3 - 3 + int'(tx_rem)), 10);
        @(negedge clk); #2
        check(!tx_valid, "R9 drained", 32'(tx_valid), 0);

        // R4/R3: fill transmit FIFO with link stalled
        tx_ready = 1'b0;
        bus_write(2'd0, 32'h0);
        for (int i = 0; i < 12; i++) bus_write(2'd2, 32'hB000_0000 + i);
        bus_read(2'd1, v);
        check(v[24] == 1'b0, "R4 afull clear at 12 queued", 32'(v[24]), 0);
        bus_write(2'd2, 32'hB000_000C);
        bus_read(2'd1, v);
        check(v[24] == 1'b1, "R4 afull set at 13 queued", 32'(v[24]), 1);
        for (int i = 13; i < DEPTH; i++) bus_write(2'd2, 32'hB000_0000 + i);
        bus_read(2'd1, v);
        check(v[0] == 1'b0, "R3 no overflow when exactly full", 32'(v[0]), 0);
        bus_write(2'd2, 32'hDEAD_BEEF);
        bus_read(2'd1, v);
        check(v[0] == 1'b1, "R3 overflow sticky", 32'(v[0]), 1);
        tx_ready = 1'b1;
        repeat (DEPTH + 2) @(negedge clk);
        #2 check(!tx_valid, "R3 dropped word never sent", 32'(tx_valid), 0);
        bus_read(2'd1, v);
        check(v[0] == 1'b1, "R3 overflow still set after drain", 32'(v[0]), 1);

        // R7: fill receive FIFO beyond depth
        for (int k = 0; k < DEPTH + 2; k++) begin
            @(negedge clk); #1;
            rx_valid = 1'b1; rx_data = 32'hC000_0000 + k;
            rx_sof = (k % 4 == 0); rx_eof = (k % 4 == 3); rx_rem = 2'(k % 4);
        end
        @(negedge clk); #1 rx_valid = 1'b0;
        check(!rx_ready, "R7 backpressure when full", 32'(rx_ready), 0);

        // R5/R6: head tags and pops
        bus_read(2'd1, v);
        check(v[31:27] == 5'b00010, "R5 head word 0 tags", v, 32'h1000_0000);
        bus_read(2'd2, v);
        check(v == 32'hC000_0000, "R6 pop word 0", v, 32'hC000_0000);
        bus_read(2'd1, v);
        check(v[31:27] == 5'b01000, "R5 head word 1 tags", v, 32'h4000_0000);
        for (int k = 1; k < DEPTH; k++) begin
            bus_read(2'd2, v);
            check(v == 32'hC000_0000 + k, "R6 pop order", v, 32'hC000_0000 + k);
        end
        bus_read(2'd2, v);
        check(v == 32'h0, "R6 read empty returns zero", v, 32'h0);
        bus_read(2'd1, v);
        check(v[27] == 1'b1 && v[31:28] == 4'h0, "R5 empty status", v, 32'h0800_0000);

        // R8: flush with queued words and overflow flag
        tx_ready = 1'b0;
        bus_write(2'd2, 32'hE000_0001);
        @(negedge clk); #1;
        rx_valid = 1'b1; rx_data = 32'hF000_0001; rx_sof = 1'b1; rx_eof = 1'b1; rx_rem = 2'd3;
        @(negedge clk); #1 rx_valid = 1'b0;
        bus_write(2'd0, 32'h0020_0000);
        bus_write(2'd2, 32'hE000_0002);
        bus_read(2'd1, v);
        check(v == 32'h0800_0000, "R8 flushed status", v, 32'h0800_0000);
        check(!tx_valid && !rx_ready, "R8 link idle in flush", {30'b0, tx_valid, rx_ready}, 0);
        bus_write(2'd0, 32'h0);
        @(negedge clk); #2
        check(rx_ready && !tx_valid, "R8 released, write during flush lost",
              {30'b0, tx_valid, rx_ready}, 1);

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule